// File: doc/BRIEF.md
# Host Interface Buffer Controller

This block sits between an external host processor and the internal logic of a slave controller. The host sees a chip select, read and write strobes, one address line, and an 8-bit data bus with a separate drive enable for the pad. Behind that interface are three registers: one input byte buffer written by the host, one output byte buffer read by the host, and one status byte. The address line chooses between the data path and the status/command path.

On the local side, the input buffer is presented as a valid/ready stream source and the output buffer as a valid/ready stream sink. Back-pressure follows the full flags. The input stream is valid while the input buffer holds an unread byte, and the local logic pops it by raising ready. The output stream is ready only while the output buffer is empty, so a local producer stalls for as long as the host has not collected the previous byte. Plain control pins write the upper status nibble, toggle a general-purpose flag, enable the interrupt outputs and enable the DMA handshake.

Host strobes are synchronous, active-low levels sampled on the block clock. Each strobe acts once, on the first cycle it is seen asserted while the block is selected.

Top module: `hif_buffer_ctrl`

## Requirements
- R1: After reset the status byte is 0x00, the input stream is not valid, the output stream is ready, the bus enable is low, both interrupt outputs are low, and the DMA request is low.
- R2: A selected host write loads the bus byte into the input buffer and sets the input-full flag (status bit 1) from the next cycle.
- R3: Each host write sets the command flag (status bit 3) to the value of the address line: 1 for a command byte and 0 for a data byte.
- R4: A selected host read with address low returns the output buffer and clears the output-full flag (status bit 0). A read with address high returns the status byte {user[3:0], bit3 command, bit2 F0, bit1 input-full, bit0 output-full} and changes nothing.
- R5: The bus enable is high only while the block is selected and the read strobe is low. At all other times it is low.
- R6: The output stream is ready exactly while output-full is clear. An accepted byte sets output-full. A byte offered while full is not taken and leaves the stored byte unchanged.
- R7: The input stream is valid exactly while input-full is set. A pop clears input-full, unless a host write lands in the same cycle, in which case the flag stays set and the new byte becomes current.
- R8: A host write while input-full is set overwrites the stored byte.
- R9: A status-write pulse loads status bits 7:4, and an F0 toggle pulse inverts status bit 2.
- R10: The output-full interrupt equals output-full and the input-full interrupt equals input-full while interrupts are enabled. Both are low while interrupts are disabled.
- R11: With DMA enabled, a request pulse sets the DMA request. A low acknowledge selects the block with the address forced low, whatever chip select and address are, and clears the request in the next cycle. With DMA disabled, request pulses are ignored.
- R12: A strobe held low for several cycles acts only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| a0 | input | 1 | Host address: 0 data, 1 status/command |
| hbus_in | input | 8 | Byte from the host bus pads |
| hbus_out | output | 8 | Byte toward the host bus pads |
| hbus_oe | output | 1 | Pad drive enable for the host bus |
| ibuf_data | output | 8 | Input buffer byte (local stream) |
| ibuf_valid | output | 1 | Input buffer holds an unread byte |
| ibuf_ready | input | 1 | Local logic pops the input byte |
| obuf_data | input | 8 | Byte offered to the output buffer |
| obuf_valid | input | 1 | Local logic offers a byte |
| obuf_ready | output | 1 | Output buffer can accept a byte |
| stat_we | input | 1 | Load status bits 7:4 |
| stat_wdata | input | 4 | Value for status bits 7:4 |
| f0_toggle | input | 1 | Invert status bit 2 |
| irq_en | input | 1 | Enable the interrupt outputs |
| irq_obf | output | 1 | Output-full interrupt |
| irq_ibf | output | 1 | Input-full interrupt |
| dma_en | input | 1 | Enable the DMA handshake |
| dma_req_set | input | 1 | Local pulse that raises a DMA request |
| drq | output | 1 | DMA request to the host |
| dack_n | input | 1 | DMA acknowledge from the host, active low |

## Verification
Two functions on the input buffer can fall in one clock edge: a host write edge and a local pop. The bench holds the pop ready high and issues a host write while an older byte is still stored. The stored byte must be popped and checked first, the flag must stay set, and the newly written byte must come out on the next cycle. The scoreboard queue settles the order of bytes, and port checks confirm the flag. The other case where two functions meet, a status write and an F0 toggle, is judged through a host status read.

// File: rtl/hif_pkg.sv
package hif_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned USER_W   = DW - 4;
  localparam int unsigned ST_OBF   = 0;
  localparam int unsigned ST_IBF   = 1;
  localparam int unsigned ST_F0    = 2;
  localparam int unsigned ST_F1    = 3;
  localparam int unsigned ST_USER  = 4;
endpackage

// File: rtl/hif_strobe.sv
// Host select qualification and one-shot strobe edge detection.
module hif_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic a0,
  input  logic dack_n,
  input  logic dma_en,
  output logic sel,
  output logic a0_eff,
  output logic dack_act,
  output logic rd_evt,
  output logic wr_evt,
  output logic rd_live
);
  logic rd_q, wr_q;

  always_comb begin
    dack_act = dma_en & ~dack_n;
    sel      = ~cs_n | dack_act;
    a0_eff   = dack_act ? 1'b0 : a0;
    rd_live  = sel & ~rd_n;
    rd_evt   = rd_live & rd_q;
    wr_evt   = sel & ~wr_n & wr_q;
  end

  // Remember previous strobe levels so a held strobe acts once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
    end
  end
endmodule

// File: rtl/hif_flags.sv
// Data buffers and status flags.
module hif_flags
  import hif_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned UW = USER_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic          rd_evt,
  input  logic          a0_eff,
  input  logic [W-1:0]  hbus_in,
  input  logic          ibuf_ready,
  input  logic [W-1:0]  obuf_data,
  input  logic          obuf_valid,
  input  logic          stat_we,
  input  logic [UW-1:0] stat_wdata,
  input  logic          f0_toggle,
  output logic [W-1:0]  ibuf_q,
  output logic [W-1:0]  obuf_q,
  output logic          ibf,
  output logic          obf,
  output logic          f0,
  output logic          f1,
  output logic [UW-1:0] user_q
);
  logic obuf_take, ibuf_pop;

  assign obuf_take = obuf_valid & ~obf;
  assign ibuf_pop  = ibuf_ready & ibf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibuf_q <= '0;
      ibf    <= 1'b0;
      f1     <= 1'b0;
    end else if (wr_evt) begin
      ibuf_q <= hbus_in;
      ibf    <= 1'b1;     // host write wins over a same-cycle pop
      f1     <= a0_eff;
    end else if (ibuf_pop) begin
      ibf    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obuf_q <= '0;
      obf    <= 1'b0;
    end else if (obuf_take) begin
      obuf_q <= obuf_data;
      obf    <= 1'b1;
    end else if (rd_evt && !a0_eff) begin
      obf    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f0     <= 1'b0;
      user_q <= '0;
    end else begin
      if (f0_toggle) f0 <= ~f0;
      if (stat_we)   user_q <= stat_wdata;
    end
  end
endmodule

// File: rtl/hif_dma.sv
// DMA request flop: set by a local pulse, cleared by acknowledge.
module hif_dma (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic dma_req_set,
  input  logic dack_act,
  output logic drq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     drq <= 1'b0;
    else if (dack_act || !dma_en)   drq <= 1'b0;
    else if (dma_req_set)           drq <= 1'b1;
  end
endmodule

// File: rtl/hif_buffer_ctrl.sv
module hif_buffer_ctrl
  import hif_pkg::*;
#(
  parameter int unsigned W  = DW,
  localparam int unsigned UW = W - 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          a0,
  input  logic [W-1:0]  hbus_in,
  output logic [W-1:0]  hbus_out,
  output logic          hbus_oe,
  output logic [W-1:0]  ibuf_data,
  output logic          ibuf_valid,
  input  logic          ibuf_ready,
  input  logic [W-1:0]  obuf_data,
  input  logic          obuf_valid,
  output logic          obuf_ready,
  input  logic          stat_we,
  input  logic [UW-1:0] stat_wdata,
  input  logic          f0_toggle,
  input  logic          irq_en,
  output logic          irq_obf,
  output logic          irq_ibf,
  input  logic          dma_en,
  input  logic          dma_req_set,
  output logic          drq,
  input  logic          dack_n
);
  logic sel, a0_eff, dack_act, rd_evt, wr_evt, rd_live;
  logic ibf, obf, f0, f1;
  logic [W-1:0]  ibuf_q, obuf_q, status;
  logic [UW-1:0] user_q;

  hif_strobe u_strobe (
    .clk, .rst_n, .cs_n, .rd_n, .wr_n, .a0, .dack_n, .dma_en,
    .sel, .a0_eff, .dack_act, .rd_evt, .wr_evt, .rd_live
  );

  hif_flags #(.W(W), .UW(UW)) u_flags (
    .clk, .rst_n, .wr_evt, .rd_evt, .a0_eff, .hbus_in, .ibuf_ready,
    .obuf_data, .obuf_valid, .stat_we, .stat_wdata, .f0_toggle,
    .ibuf_q, .obuf_q, .ibf, .obf, .f0, .f1, .user_q
  );

  hif_dma u_dma (
    .clk, .rst_n, .dma_en, .dma_req_set, .dack_act, .drq
  );

  always_comb begin
    status = '0;
    status[ST_OBF] = obf;
    status[ST_IBF] = ibf;
    status[ST_F0]  = f0;
    status[ST_F1]  = f1;
    status[W-1:ST_USER] = user_q;
  end

  assign hbus_oe    = rd_live;
  assign hbus_out   = rd_live ? (a0_eff ? status : obuf_q) : '0;
  assign ibuf_data  = ibuf_q;
  assign ibuf_valid = ibf;
  assign obuf_ready = ~obf;
  assign irq_obf    = irq_en & obf;
  assign irq_ibf    = irq_en & ibf;
endmodule

// File: rtl/hif_buffer_ctrl_chk.sv
module hif_buffer_ctrl_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_evt,
  input logic         rd_evt,
  input logic         a0_eff,
  input logic         ibf,
  input logic         obf,
  input logic         f1,
  input logic         drq,
  input logic         dack_act,
  input logic         ibuf_ready,
  input logic         obuf_valid,
  input logic [W-1:0] obuf_q
);
  p_ibf_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> ibf);
  p_cmd_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (f1 == $past(a0_eff)));
  p_obf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !a0_eff && obf) |=> !obf);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (obuf_valid && obf && !rd_evt) |=> $stable(obuf_q));
  p_pop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ibuf_ready && ibf && !wr_evt) |=> !ibf);
  p_dack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dack_act |=> !drq);
endmodule

bind hif_buffer_ctrl hif_buffer_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt),
  .a0_eff(a0_eff), .ibf(ibf), .obf(obf), .f1(f1), .drq(drq),
  .dack_act(dack_act), .ibuf_ready(ibuf_ready),
  .obuf_valid(obuf_valid), .obuf_q(obuf_q)
);

// File: tb/hif_buffer_ctrl_bench.sv
`timescale 1ns/1ps
module hif_buffer_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1, rd_n = 1, wr_n = 1, a0 = 0, dack_n = 1;
  logic [7:0] hbus_in = '0, hbus_out, ibuf_data, obuf_data = '0;
  logic hbus_oe, ibuf_valid, ibuf_ready = 0, obuf_valid = 0, obuf_ready;
  logic stat_we = 0, f0_toggle = 0, irq_en = 0, irq_obf, irq_ibf;
  logic dma_en = 0, dma_req_set = 0, drq;
  logic [3:0] stat_wdata = '0;
  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rb;

  always #10 clk = ~clk;

  hif_buffer_ctrl u_hif_buffer_ctrl (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: each local pop is compared with the oldest expected byte.
  always @(posedge clk) begin
    if (rst_n && ibuf_valid && ibuf_ready) begin
      if (exp_q.size() == 0) check(0, "R7 pop with empty scoreboard", ibuf_data, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        check(ibuf_data == e, "R7 popped byte", ibuf_data, e);
      end
    end
  end

  task automatic host_write(input logic addr, input logic [7:0] d);
    @(negedge clk);
    if (!ibuf_ready && exp_q.size() > 0) void'(exp_q.pop_back()); // R8 overwrite
    exp_q.push_back(d);
    cs_n = 0; a0 = addr; wr_n = 0; hbus_in = d;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic host_read(input logic addr, output logic [7:0] d);
    @(negedge clk);
    cs_n = 0; a0 = addr; rd_n = 0;
    #1 d = hbus_out;
    check(hbus_oe, "R5 enable during read", hbus_oe, 1);
    @(negedge clk);
    cs_n = 1; rd_n = 1;
    #1 check(!hbus_oe, "R5 enable after read", hbus_oe, 0);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!ibuf_valid && obuf_ready && !hbus_oe && !irq_obf && !irq_ibf && !drq,
          "R1 reset outputs", {ibuf_valid, obuf_ready, hbus_oe, drq}, 4'b0100);
    host_read(1, rb);
    check(rb == 8'h00, "R1 reset status", rb, 8'h00);

    // R2 R3 data write
    host_write(0, 8'h5A);
    check(ibuf_valid, "R2 input full after write", ibuf_valid, 1);
    host_read(1, rb);
    check(rb == 8'h02, "R3 data write status", rb, 8'h02);
    // R8 overwrite with a command byte, R3 command flag
    host_write(1, 8'hC3);
    host_read(1, rb);
    check(rb == 8'h0A, "R3 command write status", rb, 8'h0A);
    check(ibuf_data == 8'hC3, "R8 overwrite", ibuf_data, 8'hC3);
    // R7 pop
    @(negedge clk); ibuf_ready = 1;
    @(negedge clk); ibuf_ready = 0;
    check(!ibuf_valid, "R7 pop clears input full", ibuf_valid, 0);

    // R9 status bits: F0 toggle and user write in the same cycle
    @(negedge clk); f0_toggle = 1; stat_we = 1; stat_wdata = 4'hA;
    @(negedge clk); f0_toggle = 0; stat_we = 0;
    host_read(1, rb);
    check(rb == 8'hAC, "R9 status user and F0", rb, 8'hAC);

    // R6 local output stream
    @(negedge clk); obuf_valid = 1; obuf_data = 8'h3C;
    @(negedge clk); obuf_data = 8'h77;
    check(!obuf_ready, "R6 ready drops when full", obuf_ready, 0);
    check(!irq_obf, "R10 interrupt disabled", irq_obf, 0);
    @(negedge clk); obuf_valid = 0; irq_en = 1;
    #1 check(irq_obf && !irq_ibf, "R10 output-full interrupt", {irq_obf, irq_ibf}, 2'b10);
    host_read(1, rb);
    check(rb == 8'hAD, "R4 status read", rb, 8'hAD);
    check(!obuf_ready, "R4 status read leaves output full", obuf_ready, 0);
    host_read(0, rb);
    check(rb == 8'h3C, "R6 stalled byte not taken", rb, 8'h3C);
    check(obuf_ready, "R4 data read clears output full", obuf_ready, 1);

    // R5 no drive without select
    @(negedge clk); rd_n = 0; a0 = 0;
    #1 check(!hbus_oe, "R5 no drive when deselected", hbus_oe, 0);
    @(negedge clk); rd_n = 1;

    // R12 held write strobe acts once
    @(negedge clk); exp_q.push_back(8'h44);
    cs_n = 0; a0 = 0; wr_n = 0; hbus_in = 8'h44;
    @(negedge clk); ibuf_ready = 1;
    check(irq_ibf, "R10 input-full interrupt", irq_ibf, 1);
    @(negedge clk); ibuf_ready = 0;
    @(negedge clk);
    check(!ibuf_valid, "R12 held strobe acts once", ibuf_valid, 1'b0);
    cs_n = 1; wr_n = 1;

    // R7 write and pop in the same cycle
    host_write(0, 8'h11);
    @(negedge clk); ibuf_ready = 1;
    exp_q.push_back(8'h22);
    cs_n = 0; a0 = 0; wr_n = 0; hbus_in = 8'h22;
    @(negedge clk); cs_n = 1; wr_n = 1;
    check(ibuf_valid && ibuf_data == 8'h22, "R7 write wins over pop", ibuf_data, 8'h22);
    @(negedge clk); ibuf_ready = 0;
    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

    // R11 DMA
    @(negedge clk); dma_req_set = 1;
    @(negedge clk); dma_req_set = 0;
    check(!drq, "R11 request ignored while disabled", drq, 0);
    dma_en = 1; dma_req_set = 1;
    @(negedge clk); dma_req_set = 0;
    check(drq, "R11 request set", drq, 1);
    obuf_valid = 1; obuf_data = 8'h99;
    @(negedge clk); obuf_valid = 0;
    dack_n = 0; a0 = 1; rd_n = 0;
    #1 check(hbus_oe && hbus_out == 8'h99, "R11 acknowledge reads data", hbus_out, 8'h99);
    @(negedge clk); dack_n = 1; rd_n = 1;
    check(!drq, "R11 acknowledge clears request", drq, 0);
    check(obuf_ready, "R11 acknowledge read clears output full", obuf_ready, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule